// File: doc/BRIEF.md
# TDM Serial Audio Slot Engine

A master-mode frame engine for a serial audio port. It divides the system clock down to a bit clock, generates the frame sync and splits each frame into 16-bit time slots. Up to two transmit words, left and right, are shifted out most significant bit first. Each word goes into whichever slot its channel is mapped to. In the same way, up to two receive words are assembled from their own mapped slots.

Frame sync comes in one of two styles. In pulse style, a one-bit pulse precedes slot 0 by one bit. In level style, the sync line is high for the left half-frame and low for the right half-frame, with no delay. The edge used to sample receive data can be selected, and transmit data changes on the opposite edge. Frames are 32 or 64 bits long. All settings are taken up only at a frame boundary.

Parallel words enter and leave through single-word valid/ready holding registers. Two sticky flags record a missing transmit word and a receive word that was lost.

Top module: `tdm_slot_engine`

## Requirements
- R1: While reset is held, sck_o, fsync_o and sdo_o are 0, both transmit ready outputs are 1, both receive valid outputs are 0, and both error flags are 0.
- R2: The bit clock period is 2*HALF_DIV system clocks. With cfg_rise_smp=1, sdo_o changes only while sck_o is low, and data is sampled on rising edges. With cfg_rise_smp=0, sdo_o changes only while sck_o is high, and data is sampled on falling edges.
- R3: cfg_len_code=4'b1101 selects a 64-bit frame (4 slots). Every other code, 4'b1100 among them, selects a 32-bit frame (2 slots).
- R4: With cfg_lr_mode=0, fsync_o is high for exactly one bit period, the last bit of each frame. The MSB of slot 0 follows in the next bit.
- R5: With cfg_lr_mode=1, fsync_o is high for bits 0 to N/2-1 of an N-bit frame and low for the rest. The MSB of slot 0 is sent in bit 0.
- R6: Slot s occupies frame bits 16*s to 16*s+15. An enabled transmit channel whose 4-bit slot number equals s sends its word there, MSB first. If both transmit channels name the same slot, the left word is sent.
- R7: During a slot that no enabled transmit channel names, sdo_o is 0.
- R8: An enabled receive channel assembles the 16 bits of its named slot, MSB first. It presents the word with valid held and data stable until ready is seen. A disabled receive channel never raises valid.
- R9: Changes to length, style, edge and slot settings take effect only at the start of the next frame. The frame already in progress completes with the old settings.
- R10: If a transmit channel's holding register is empty when its slot starts, zeros are sent in that slot and tx_underrun_o is set. The flag stays set until reset.
- R11: If a receive word completes while the previous word is still unread, the new word is dropped and rx_overrun_o is set. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_lr_mode | input | 1 | 0 = pulse sync, 1 = half-frame level sync |
| cfg_rise_smp | input | 1 | 1 = sample on rising bit clock edge, 0 = falling |
| cfg_len_code | input | 4 | Frame length code |
| cfg_txl_en | input | 1 | Left transmit enable |
| cfg_txl_slot | input | 4 | Left transmit slot number |
| cfg_txr_en | input | 1 | Right transmit enable |
| cfg_txr_slot | input | 4 | Right transmit slot number |
| cfg_rxl_en | input | 1 | Left receive enable |
| cfg_rxl_slot | input | 4 | Left receive slot number |
| cfg_rxr_en | input | 1 | Right receive enable |
| cfg_rxr_slot | input | 4 | Right receive slot number |
| txl_data | input | 16 | Left transmit word |
| txl_valid | input | 1 | Left transmit word offered |
| txl_ready | output | 1 | Left transmit holding register empty |
| txr_data | input | 16 | Right transmit word |
| txr_valid | input | 1 | Right transmit word offered |
| txr_ready | output | 1 | Right transmit holding register empty |
| rxl_data | output | 16 | Left received word |
| rxl_valid | output | 1 | Left received word present |
| rxl_ready | input | 1 | Left received word taken |
| rxr_data | output | 16 | Right received word |
| rxr_valid | output | 1 | Right received word present |
| rxr_ready | input | 1 | Right received word taken |
| sck_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |
| sdo_o | output | 1 | Serial transmit data |
| sdi_i | input | 1 | Serial receive data |
| tx_underrun_o | output | 1 | Sticky transmit underrun flag |
| rx_overrun_o | output | 1 | Sticky receive overrun flag |

## Verification
The hardest case to reach is a settings change in the middle of a frame. The change has to arrive well after one boundary and well before the next. The stimulus waits for a sync pulse, lets five more bits pass, then switches the length code. It then counts bits until the following two pulses, which must be 64 and then 32 bits apart. The receive side is driven by looping sdo_o back to sdi_i, so crossed slot mappings show up as swapped words. Underrun and overrun are provoked by stopping the transmit feeder and the receive drain.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

    localparam int SLOT_SEL_W = 4;

    typedef struct packed {
        logic                  en;
        logic [SLOT_SEL_W-1:0] slot;
    } chan_map_t;

    typedef struct packed {
        logic       lr_mode;
        logic       rise_smp;
        logic [3:0] len_code;
        chan_map_t  txl;
        chan_map_t  txr;
        chan_map_t  rxl;
        chan_map_t  rxr;
    } tdm_cfg_t;

    function automatic logic is_long_frame(input logic [3:0] code);
        return code == 4'b1101;
    endfunction

endpackage

// File: rtl/tdm_bitclk.sv
module tdm_bitclk #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_smp_i,
    output logic launch_o,
    output logic sample_o,
    output logic sck_o
);
    localparam int PH_W = (HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * HALF_DIV - 1);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            sck;
    } bclk_st_t;

    bclk_st_t st_q, st_d;

    assign launch_o = (st_q.ph == PH_LAST);
    assign sample_o = (st_q.ph == PH_MID);
    assign sck_o    = st_q.sck;

    always_comb begin
        st_d = st_q;
        if (launch_o) begin
            st_d.ph  = '0;
            st_d.sck = ~rise_smp_i;
        end else begin
            st_d.ph = st_q.ph + 1'b1;
        end
        if (sample_o) begin
            st_d.sck = rise_smp_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx import tdm_slot_pkg::*; #(
    parameter int SLOT_W = 16,
    parameter int SID_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              slot_start_i,
    input  logic [SID_W-1:0]  slot_i,
    input  chan_map_t         map_l_i,
    input  chan_map_t         map_r_i,
    input  logic [SLOT_W-1:0] txl_data_i,
    input  logic              txl_valid_i,
    output logic              txl_ready_o,
    input  logic [SLOT_W-1:0] txr_data_i,
    input  logic              txr_valid_i,
    output logic              txr_ready_o,
    output logic              sdo_o,
    output logic              underrun_o
);
    typedef struct packed {
        logic [1:0][SLOT_W-1:0] hold;
        logic [1:0]             full;
        logic [SLOT_W-1:0]      shift;
        logic                   active;
        logic                   sdo;
        logic                   unf;
    } tx_st_t;

    tx_st_t st_q, st_d;

    logic [1:0][SLOT_W-1:0] in_data;
    logic [1:0]             in_valid;
    logic                   hit_l, hit_r, pick;

    assign in_data  = {txr_data_i, txl_data_i};
    assign in_valid = {txr_valid_i, txl_valid_i};
    assign hit_l    = map_l_i.en && (map_l_i.slot == SLOT_SEL_W'(slot_i));
    assign hit_r    = map_r_i.en && (map_r_i.slot == SLOT_SEL_W'(slot_i));
    assign pick     = ~hit_l;

    assign txl_ready_o = ~st_q.full[0];
    assign txr_ready_o = ~st_q.full[1];
    assign sdo_o       = st_q.sdo;
    assign underrun_o  = st_q.unf;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < 2; c++) begin
            if (in_valid[c] && !st_q.full[c]) begin
                st_d.hold[c] = in_data[c];
                st_d.full[c] = 1'b1;
            end
        end
        if (launch_i) begin
            if (slot_start_i) begin
                st_d.active = hit_l || hit_r;
                st_d.shift  = '0;
                if (hit_l || hit_r) begin
                    if (st_q.full[pick]) begin
                        st_d.shift      = st_q.hold[pick];
                        st_d.full[pick] = 1'b0;
                    end else begin
                        st_d.unf = 1'b1;
                    end
                end
            end else begin
                st_d.shift = {st_q.shift[SLOT_W-2:0], 1'b0};
            end
            st_d.sdo = st_d.active && st_d.shift[SLOT_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx import tdm_slot_pkg::*; #(
    parameter int SLOT_W = 16,
    parameter int SID_W  = 2,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic [SID_W-1:0]  slot_i,
    input  logic [IDX_W-1:0]  bit_i,
    input  chan_map_t         map_l_i,
    input  chan_map_t         map_r_i,
    input  logic              sdi_i,
    input  logic              rxl_ready_i,
    output logic [SLOT_W-1:0] rxl_data_o,
    output logic              rxl_valid_o,
    input  logic              rxr_ready_i,
    output logic [SLOT_W-1:0] rxr_data_o,
    output logic              rxr_valid_o,
    output logic              overrun_o
);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(SLOT_W - 1);

    typedef struct packed {
        logic [1:0][SLOT_W-1:0] shift;
        logic [1:0][SLOT_W-1:0] hold;
        logic [1:0]             full;
        logic                   ovf;
    } rx_st_t;

    rx_st_t st_q, st_d;

    logic [1:0] hit;
    logic [1:0] take;
    logic [1:0][SLOT_W-1:0] word;

    assign take = {rxr_ready_i, rxl_ready_i};

    for (genvar c = 0; c < 2; c++) begin : g_hit
        chan_map_t m;
        assign m        = (c == 0) ? map_l_i : map_r_i;
        assign hit[c]   = m.en && (m.slot == SLOT_SEL_W'(slot_i));
        assign word[c]  = {st_q.shift[c][SLOT_W-2:0], sdi_i};
    end

    assign rxl_data_o  = st_q.hold[0];
    assign rxl_valid_o = st_q.full[0];
    assign rxr_data_o  = st_q.hold[1];
    assign rxr_valid_o = st_q.full[1];
    assign overrun_o   = st_q.ovf;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < 2; c++) begin
            if (take[c] && st_q.full[c]) begin
                st_d.full[c] = 1'b0;
            end
            if (sample_i && hit[c]) begin
                st_d.shift[c] = word[c];
                if (bit_i == LAST_BIT) begin
                    if (st_q.full[c] && !take[c]) begin
                        st_d.ovf = 1'b1;
                    end else begin
                        st_d.hold[c] = word[c];
                        st_d.full[c] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tdm_slot_engine.sv
module tdm_slot_engine import tdm_slot_pkg::*; #(
    parameter int HALF_DIV = 2,
    parameter int SLOT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_lr_mode,
    input  logic              cfg_rise_smp,
    input  logic [3:0]        cfg_len_code,
    input  logic              cfg_txl_en,
    input  logic [3:0]        cfg_txl_slot,
    input  logic              cfg_txr_en,
    input  logic [3:0]        cfg_txr_slot,
    input  logic              cfg_rxl_en,
    input  logic [3:0]        cfg_rxl_slot,
    input  logic              cfg_rxr_en,
    input  logic [3:0]        cfg_rxr_slot,
    input  logic [SLOT_W-1:0] txl_data,
    input  logic              txl_valid,
    output logic              txl_ready,
    input  logic [SLOT_W-1:0] txr_data,
    input  logic              txr_valid,
    output logic              txr_ready,
    output logic [SLOT_W-1:0] rxl_data,
    output logic              rxl_valid,
    input  logic              rxl_ready,
    output logic [SLOT_W-1:0] rxr_data,
    output logic              rxr_valid,
    input  logic              rxr_ready,
    output logic              sck_o,
    output logic              fsync_o,
    output logic              sdo_o,
    input  logic              sdi_i,
    output logic              tx_underrun_o,
    output logic              rx_overrun_o
);
    localparam int MAX_SLOTS = 4;
    localparam int POS_W     = $clog2(SLOT_W * MAX_SLOTS);
    localparam int IDX_W     = $clog2(SLOT_W);
    localparam int SID_W     = POS_W - IDX_W;
    localparam logic [POS_W-1:0] SHORT_LAST = POS_W'(2 * SLOT_W - 1);
    localparam logic [POS_W-1:0] LONG_LAST  = POS_W'(4 * SLOT_W - 1);
    localparam logic [POS_W-1:0] SHORT_HALF = POS_W'(SLOT_W);
    localparam logic [POS_W-1:0] LONG_HALF  = POS_W'(2 * SLOT_W);

    typedef struct packed {
        tdm_cfg_t         cfg;
        logic [POS_W-1:0] pos;
        logic             fsync;
    } seq_st_t;

    seq_st_t st_q, st_d;
    tdm_cfg_t cfg_in;
    logic launch_w, sample_w, wrap;
    logic slot_start;
    logic [POS_W-1:0] last_q, last_d, half_d;

    assign cfg_in = '{lr_mode:  cfg_lr_mode,
                      rise_smp: cfg_rise_smp,
                      len_code: cfg_len_code,
                      txl:      '{en: cfg_txl_en, slot: cfg_txl_slot},
                      txr:      '{en: cfg_txr_en, slot: cfg_txr_slot},
                      rxl:      '{en: cfg_rxl_en, slot: cfg_rxl_slot},
                      rxr:      '{en: cfg_rxr_en, slot: cfg_rxr_slot}};

    always_comb begin
        st_d   = st_q;
        last_q = is_long_frame(st_q.cfg.len_code) ? LONG_LAST : SHORT_LAST;
        wrap   = (st_q.pos >= last_q);
        if (launch_w) begin
            st_d.pos = wrap ? '0 : st_q.pos + 1'b1;
            if (wrap) begin
                st_d.cfg = cfg_in;
            end
        end
        last_d = is_long_frame(st_d.cfg.len_code) ? LONG_LAST : SHORT_LAST;
        half_d = is_long_frame(st_d.cfg.len_code) ? LONG_HALF : SHORT_HALF;
        if (launch_w) begin
            st_d.fsync = st_d.cfg.lr_mode ? (st_d.pos < half_d) : (st_d.pos == last_d);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pos <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fsync_o    = st_q.fsync;
    assign slot_start = (st_d.pos[IDX_W-1:0] == '0);

    tdm_bitclk #(.HALF_DIV(HALF_DIV)) u_bitclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_smp_i (st_d.cfg.rise_smp),
        .launch_o   (launch_w),
        .sample_o   (sample_w),
        .sck_o      (sck_o)
    );

    tdm_tx #(.SLOT_W(SLOT_W), .SID_W(SID_W)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_i     (launch_w),
        .slot_start_i (slot_start),
        .slot_i       (st_d.pos[POS_W-1:IDX_W]),
        .map_l_i      (st_d.cfg.txl),
        .map_r_i      (st_d.cfg.txr),
        .txl_data_i   (txl_data),
        .txl_valid_i  (txl_valid),
        .txl_ready_o  (txl_ready),
        .txr_data_i   (txr_data),
        .txr_valid_i  (txr_valid),
        .txr_ready_o  (txr_ready),
        .sdo_o        (sdo_o),
        .underrun_o   (tx_underrun_o)
    );

    tdm_rx #(.SLOT_W(SLOT_W), .SID_W(SID_W), .IDX_W(IDX_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_i    (sample_w),
        .slot_i      (st_q.pos[POS_W-1:IDX_W]),
        .bit_i       (st_q.pos[IDX_W-1:0]),
        .map_l_i     (st_q.cfg.rxl),
        .map_r_i     (st_q.cfg.rxr),
        .sdi_i       (sdi_i),
        .rxl_ready_i (rxl_ready),
        .rxl_data_o  (rxl_data),
        .rxl_valid_o (rxl_valid),
        .rxr_ready_i (rxr_ready),
        .rxr_data_o  (rxr_data),
        .rxr_valid_o (rxr_valid),
        .overrun_o   (rx_overrun_o)
    );
endmodule

// File: rtl/tdm_slot_engine_chk.sv
module tdm_slot_engine_chk #(
    parameter int SLOT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              launch,
    input logic              sample,
    input logic              sck,
    input logic              fsync,
    input logic              sdo,
    input logic              unf,
    input logic              ovf,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [SLOT_W-1:0] rx_data,
    input logic              tx_valid,
    input logic              tx_ready
);
    a_r2_sck_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch && !sample) |=> $stable(sck));

    a_r4_lines_move_at_launch: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> ($stable(fsync) && $stable(sdo)));

    a_r8_rx_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    a_r6_tx_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> unf);

    a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
endmodule

bind tdm_slot_engine tdm_slot_engine_chk #(.SLOT_W(SLOT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch_w),
    .sample   (sample_w),
    .sck      (sck_o),
    .fsync    (fsync_o),
    .sdo      (sdo_o),
    .unf      (tx_underrun_o),
    .ovf      (rx_overrun_o),
    .rx_valid (rxl_valid),
    .rx_ready (rxl_ready),
    .rx_data  (rxl_data),
    .tx_valid (txl_valid),
    .tx_ready (txl_ready)
);

// File: tb/tdm_slot_engine_tb_top.sv
`timescale 1ns/1ps
module tdm_slot_engine_tb_top;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_lr_mode = 0, cfg_rise_smp = 0;
    logic [3:0] cfg_len_code = 4'b1101;
    logic cfg_txl_en = 1, cfg_txr_en = 0, cfg_rxl_en = 1, cfg_rxr_en = 0;
    logic [3:0] cfg_txl_slot = 0, cfg_txr_slot = 0, cfg_rxl_slot = 0, cfg_rxr_slot = 0;
    logic [15:0] txl_data = 0, txr_data = 0, rxl_data, rxr_data;
    logic txl_valid = 0, txr_valid = 0, txl_ready, txr_ready;
    logic rxl_valid, rxr_valid, rxl_ready = 0, rxr_ready = 0;
    logic sck, fsync, sdo, unf, ovf;

    logic [15:0] word_l = 16'hA5C3, word_r = 16'h3C5A;
    logic feed_l = 1, feed_r = 1, drain_l = 1, drain_r = 1;
    logic [15:0] last_l = 0, last_r = 0;
    int n_vec = 0, n_bad = 0;

    always #4 clk = ~clk;

    tdm_slot_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_lr_mode(cfg_lr_mode), .cfg_rise_smp(cfg_rise_smp), .cfg_len_code(cfg_len_code),
        .cfg_txl_en(cfg_txl_en), .cfg_txl_slot(cfg_txl_slot),
        .cfg_txr_en(cfg_txr_en), .cfg_txr_slot(cfg_txr_slot),
        .cfg_rxl_en(cfg_rxl_en), .cfg_rxl_slot(cfg_rxl_slot),
        .cfg_rxr_en(cfg_rxr_en), .cfg_rxr_slot(cfg_rxr_slot),
        .txl_data(txl_data), .txl_valid(txl_valid), .txl_ready(txl_ready),
        .txr_data(txr_data), .txr_valid(txr_valid), .txr_ready(txr_ready),
        .rxl_data(rxl_data), .rxl_valid(rxl_valid), .rxl_ready(rxl_ready),
        .rxr_data(rxr_data), .rxr_valid(rxr_valid), .rxr_ready(rxr_ready),
        .sck_o(sck), .fsync_o(fsync), .sdo_o(sdo), .sdi_i(sdo),
        .tx_underrun_o(unf), .rx_overrun_o(ovf)
    );

    initial forever begin
        @(negedge clk);
        txl_valid = feed_l; txl_data = word_l;
        txr_valid = feed_r; txr_data = word_r;
        rxl_ready = drain_l; rxr_ready = drain_r;
        if (rxl_valid && rxl_ready) last_l = rxl_data;
        if (rxr_valid && rxr_ready) last_r = rxr_data;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    function automatic int frame_bits();
        return (cfg_len_code == 4'b1101) ? 64 : 32;
    endfunction

    task automatic samp();
        if (cfg_rise_smp) @(posedge sck); else @(negedge sck);
        #1;
    endtask

    task automatic settle();
        repeat (3 * 64 * 2 * HALF) @(negedge clk);
    endtask

    task automatic cap_frame(output logic [63:0] cs, output logic [63:0] cf);
        int fb = frame_bits();
        logic p;
        cs = '0; cf = '0;
        if (!cfg_lr_mode) begin
            do samp(); while (!fsync);
            for (int i = 0; i < fb; i++) begin
                samp(); cs[i] = sdo; cf[i] = fsync;
            end
        end else begin
            samp(); p = fsync;
            while (1) begin
                samp();
                if (fsync && !p) break;
                p = fsync;
            end
            cs[0] = sdo; cf[0] = fsync;
            for (int i = 1; i < fb; i++) begin
                samp(); cs[i] = sdo; cf[i] = fsync;
            end
        end
    endtask

    function automatic logic [63:0] exp_sdo(input logic [15:0] wl, input logic [15:0] wr);
        logic [63:0] r = '0;
        for (int i = 0; i < frame_bits(); i++) begin
            int s = i / 16;
            int b = 15 - (i % 16);
            if (cfg_txl_en && cfg_txl_slot == 4'(s)) r[i] = wl[b];
            else if (cfg_txr_en && cfg_txr_slot == 4'(s)) r[i] = wr[b];
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_fs();
        logic [63:0] r = '0;
        for (int i = 0; i < frame_bits(); i++)
            r[i] = cfg_lr_mode ? (i < frame_bits() / 2) : (i == frame_bits() - 1);
        return r;
    endfunction

    task automatic chk_edges(input string tag);
        logic prev = sdo;
        int bad = 0, moves = 0;
        repeat (400) begin
            @(negedge clk);
            if (sdo !== prev) begin
                moves++;
                if (sck !== ~cfg_rise_smp) bad++;
            end
            prev = sdo;
        end
        chk(bad == 0 && moves > 0, tag, 64'(bad), 64'(0));
    endtask

    task automatic gap(output int n);
        do samp(); while (!fsync);
        n = 0;
        do begin samp(); n++; end while (!fsync);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (5) @(negedge clk);
        chk({sck, fsync, sdo} == 3'b000, "R1 serial lines in reset", 64'({sck, fsync, sdo}), 64'(0));
        chk({txl_ready, txr_ready, rxl_valid, rxr_valid} == 4'b1100, "R1 handshake in reset",
            64'({txl_ready, txr_ready, rxl_valid, rxr_valid}), 64'(4'b1100));
        chk({unf, ovf} == 2'b00, "R1 flags in reset", 64'({unf, ovf}), 64'(0));
        rst_n = 1;
    endtask

    task automatic t_pulse_mono();
        logic [63:0] cs, cf;
        cfg_lr_mode = 0; cfg_rise_smp = 0; cfg_len_code = 4'b1101;
        cfg_txl_en = 1; cfg_txl_slot = 0; cfg_txr_en = 0; cfg_txr_slot = 0;
        cfg_rxl_en = 1; cfg_rxl_slot = 0; cfg_rxr_en = 0; cfg_rxr_slot = 0;
        word_l = 16'hA5C3; word_r = 16'h3C5A;
        settle();
        cap_frame(cs, cf);
        chk(cf == exp_fs(), "R4 pulse in last bit, 64-bit frame R3", cf, exp_fs());
        chk(cs == exp_sdo(word_l, word_r), "R6 R7 mono slot 0, idle slots low", cs, exp_sdo(word_l, word_r));
        chk(last_l == word_l, "R8 left receive from slot 0", 64'(last_l), 64'(word_l));
        chk(rxr_valid == 1'b0, "R8 disabled right receive", 64'(rxr_valid), 64'(0));
        chk_edges("R2 falling-sample launch while sck high");
    endtask

    task automatic t_lr_stereo();
        logic [63:0] cs, cf;
        time t0, t1;
        cfg_lr_mode = 1; cfg_rise_smp = 1; cfg_len_code = 4'b1100;
        cfg_txr_en = 1; cfg_txr_slot = 1; cfg_rxr_en = 1; cfg_rxr_slot = 1;
        word_l = 16'h96E1; word_r = 16'h3C5A;
        settle();
        cap_frame(cs, cf);
        chk(cf == exp_fs(), "R5 level sync high first half", cf, exp_fs());
        chk(cs == exp_sdo(word_l, word_r), "R5 R6 stereo data no delay", cs, exp_sdo(word_l, word_r));
        chk(last_l == word_l && last_r == word_r, "R8 stereo receive",
            {32'(last_l), 32'(last_r)}, {32'(word_l), 32'(word_r)});
        chk_edges("R2 rising-sample launch while sck low");
        @(posedge sck); t0 = $time;
        @(posedge sck); t1 = $time;
        chk(t1 - t0 == 2 * HALF * 8, "R2 bit clock period", 64'(t1 - t0), 64'(2 * HALF * 8));
    endtask

    task automatic t_remap();
        logic [63:0] cs, cf;
        cfg_lr_mode = 0; cfg_rise_smp = 0; cfg_len_code = 4'b1101;
        cfg_txl_slot = 3; cfg_txr_slot = 1; cfg_rxl_slot = 1; cfg_rxr_slot = 3;
        word_l = 16'hF00D; word_r = 16'h8421;
        settle();
        cap_frame(cs, cf);
        chk(cs == exp_sdo(word_l, word_r), "R6 R7 left slot 3 right slot 1", cs, exp_sdo(word_l, word_r));
        chk(last_l == word_r && last_r == word_l, "R8 crossed receive mapping",
            {32'(last_l), 32'(last_r)}, {32'(word_r), 32'(word_l)});
    endtask

    task automatic t_same_slot();
        logic [63:0] cs, cf;
        cfg_txl_slot = 2; cfg_txr_slot = 2; cfg_rxr_slot = 2;
        word_l = 16'h5AA5; word_r = 16'hFFFF;
        settle();
        cap_frame(cs, cf);
        chk(cs == exp_sdo(word_l, word_r), "R6 left wins shared slot", cs, exp_sdo(word_l, word_r));
        chk(last_r == word_l, "R8 receive of shared slot", 64'(last_r), 64'(word_l));
    endtask

    task automatic t_lengths();
        int n;
        cfg_len_code = 4'b0111;
        settle(); gap(n);
        chk(n == 32, "R3 other code gives 32", 64'(n), 64'(32));
        cfg_len_code = 4'b1100;
        settle(); gap(n);
        chk(n == 32, "R3 code 1100 gives 32", 64'(n), 64'(32));
        cfg_len_code = 4'b1101;
        settle(); gap(n);
        chk(n == 64, "R3 code 1101 gives 64", 64'(n), 64'(64));
    endtask

    task automatic t_latch();
        int n = 0, n2 = 0;
        do samp(); while (!fsync);
        repeat (5) begin samp(); n++; end
        cfg_len_code = 4'b1100;
        do begin samp(); n++; end while (!fsync);
        chk(n == 64, "R9 running frame keeps old length", 64'(n), 64'(64));
        do begin samp(); n2++; end while (!fsync);
        chk(n2 == 32, "R9 next frame uses new length", 64'(n2), 64'(32));
    endtask

    task automatic t_overrun();
        chk(ovf == 1'b0, "R11 no overrun while drained", 64'(ovf), 64'(0));
        cfg_txl_slot = 0; cfg_rxl_slot = 0; cfg_txr_slot = 1; cfg_rxr_slot = 1;
        word_l = 16'hC0DE;
        settle();
        drain_l = 0;
        settle();
        chk(ovf == 1'b1, "R11 overrun set", 64'(ovf), 64'(1));
        chk(rxl_valid && rxl_data == 16'hC0DE, "R11 held word kept", 64'(rxl_data), 64'(16'hC0DE));
        drain_l = 1;
        settle();
        chk(ovf == 1'b1, "R11 overrun sticky", 64'(ovf), 64'(1));
    endtask

    task automatic t_underrun();
        logic [63:0] cs, cf;
        chk(unf == 1'b0, "R10 no underrun while fed", 64'(unf), 64'(0));
        feed_l = 0;
        settle();
        cap_frame(cs, cf);
        chk(cs == exp_sdo(16'h0000, word_r), "R10 zeros in starved slot", cs, exp_sdo(16'h0000, word_r));
        chk(unf == 1'b1, "R10 underrun set", 64'(unf), 64'(1));
        feed_l = 1;
        settle();
        chk(unf == 1'b1, "R10 underrun sticky", 64'(unf), 64'(1));
    endtask

    initial begin
        #(150000 * 8);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_pulse_mono();
        t_lr_stereo();
        t_remap();
        t_same_slot();
        t_lengths();
        t_latch();
        t_overrun();
        t_underrun();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule